// File: doc/BRIEF.md
# Conductance-Based Integrate-and-Fire Step Engine

This block advances the state of one digitally simulated spiking neuron by a single time step. A caller presents the summed excitatory weight, the summed inhibitory weight and an external input term, then pulses `start`. The engine first decays both synaptic conductances with the new weight added. It then forms the total conductance and the steady-state membrane potential from a conductance-weighted mix of the reversal potentials. Finally it relaxes the membrane potential toward that steady state, using a decay factor looked up in a table indexed by the total conductance. The step ends with a strict threshold test that can raise a spike, reset the potential and start a refractory hold.

All values are 16-bit signed fixed point with 8 fractional bits. The neuron constants and the 64-entry decay table are written through a simple write port before the simulation runs. The division for the steady-state potential is done by a shift-and-subtract divider, one quotient bit per cycle. `busy` covers the whole step, and `done` pulses once when the results are ready.

Top module: `nrn_step_top`

## Requirements
- R1: After reset, `busy`, `done` and `spike` are 0, and `vMem`, `gExc`, `gInh` and `stepCount` are all 0.
- R2: A write with `cfgWe` high stores `cfgData`. When `cfgAddr[6]` is 1, it goes into decay table entry `cfgAddr[5:0]`. When `cfgAddr[6]` is 0, `cfgAddr[2:0]` selects the parameter: 0 excitatory decay factor, 1 inhibitory decay factor, 2 leak conductance, 3 resting potential, 4 excitatory reversal potential, 5 inhibitory reversal potential, 6 firing threshold, 7 refractory length (low 8 bits).
- R3: Each step sets each conductance to mul(sat(g + summed weight), decay factor). Here mul is the Q8.8 product rounded toward zero, and every result saturates to [-32768, 32767].
- R4: The total conductance is sat(sat(leak + gExc) + gInh), raised to 1 LSB if it is below 1. The steady-state potential is (leak·rest + gExc·Eexc + gInh·Einh + 256·iExt) divided by the total conductance. The numerator is kept at full precision, the quotient is truncated toward zero and the result is saturated.
- R5: Outside refraction, the candidate potential is sat(vInf + mul(sat(vMem − vInf), table[gTot[14:9]])).
- R6: If the candidate is strictly greater than the threshold, `spike` is 1 for that step and `vMem` becomes the resting potential. Otherwise `spike` is 0 and `vMem` takes the candidate value. `spike` holds until the next step completes.
- R7: After a spike, the next N steps are refractory, where N is the refractory length. In those steps `vMem` is unchanged and `spike` is 0, but the conductances still update.
- R8: `busy` rises on the accepted `start` and stays high through the cycle in which `done` is high. `done` is a one-cycle pulse. A `start` that arrives while `busy` is high is ignored.
- R9: `stepCount` increases by one per completed step, in the cycle after `done`.
- R10: `done` is first high in the 38th clock cycle counted from the edge that accepts `start`, with that edge counted as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Parameter/table write strobe |
| cfgAddr | input | 7 | Write address (bit 6 selects table) |
| cfgData | input | 16 | Write data |
| start | input | 1 | Begin one time step |
| sumExc | input | 16 | Summed excitatory weight, Q8.8 |
| sumInh | input | 16 | Summed inhibitory weight, Q8.8 |
| iExt | input | 16 | External input term, Q8.8 |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| spike | output | 1 | Spike flag of the last completed step |
| vMem | output | 16 | Membrane potential, Q8.8 |
| gExc | output | 16 | Excitatory conductance, Q8.8 |
| gInh | output | 16 | Inhibitory conductance, Q8.8 |
| stepCount | output | 16 | Completed step counter |

## Verification
A wrong conductance shows on `gExc` or `gInh` at the end of the same step. It also shifts `vMem` in that step and all later ones, because errors accumulate through the state. A fault in the divider or the table lookup appears as a wrong `vMem` at the first `done` after it occurs. A faulty refractory counter shows as a spike, or a moved potential, during the steps that should hold. Control faults show within one step as a changed `done` latency, a repeated `done`, or a wrong `stepCount`.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
  localparam int DataW = 16;
  localparam int FracW = 8;
  localparam int WideW = 2*DataW + 4;

  typedef logic signed [DataW-1:0] q_t;

  typedef struct packed {
    logic latchIn;
    logic updCond;
    logic prepDiv;
    logic divStep;
    logic relax;
    logic bumpTime;
  } nrnStrobe_t;

  // clamp a wide signed value into the Q8.8 range
  function automatic q_t satNarrow(input logic signed [WideW-1:0] x);
    logic signed [WideW-1:0] hi, lo;
    hi = {{(WideW-DataW+1){1'b0}}, {(DataW-1){1'b1}}};
    lo = ~hi;
    if (x > hi)      return hi[DataW-1:0];
    else if (x < lo) return lo[DataW-1:0];
    else             return x[DataW-1:0];
  endfunction

  function automatic q_t satAdd(input q_t a, input q_t b);
    return satNarrow(WideW'(a) + WideW'(b));
  endfunction

  function automatic q_t satSub(input q_t a, input q_t b);
    return satNarrow(WideW'(a) - WideW'(b));
  endfunction

  // Q8.8 product, truncated toward zero, saturated
  function automatic q_t mulQ(input q_t a, input q_t b);
    logic signed [2*DataW-1:0] p, adj;
    p   = a * b;
    adj = (p < 0) ? p + ((1 << FracW) - 1) : p;
    return satNarrow(WideW'(adj >>> FracW));
  endfunction
endpackage

// File: rtl/nrn_ctrl.sv
module nrn_ctrl
  import nrn_pkg::*;
#(
  parameter int DivSteps = 34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output nrnStrobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int CntW    = $clog2(DivSteps + 1);
  localparam int Latency = DivSteps + 4;
  localparam int LatW    = $clog2(Latency + 1) + 1;

  typedef enum logic [2:0] {S_IDLE, S_COND, S_PREP, S_DIV, S_RELAX, S_FIN} state_t;

  state_t state, nextState;
  logic [CntW-1:0] divCnt;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (start) nextState = S_COND;
      S_COND:  nextState = S_PREP;
      S_PREP:  nextState = S_DIV;
      S_DIV:   if (divCnt == CntW'(DivSteps - 1)) nextState = S_RELAX;
      S_RELAX: nextState = S_FIN;
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
    end else begin
      state <= nextState;
      if (state == S_DIV) divCnt <= divCnt + 1'b1;
      else                divCnt <= '0;
    end
  end

  always_comb begin
    stb.latchIn  = (state == S_IDLE) && start;
    stb.updCond  = (state == S_COND);
    stb.prepDiv  = (state == S_PREP);
    stb.divStep  = (state == S_DIV);
    stb.relax    = (state == S_RELAX);
    stb.bumpTime = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  // cycle counter used only by the latency check
  logic [LatW-1:0] latCnt;
  always_ff @(posedge clk) begin
    if (!rstN)            latCnt <= '0;
    else if (stb.latchIn) latCnt <= LatW'(1);
    else if (busy)        latCnt <= latCnt + 1'b1;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (latCnt == LatW'(Latency)));
endmodule

// File: rtl/nrn_datapath.sv
module nrn_datapath
  import nrn_pkg::*;
#(
  parameter int TableAddrW = 6,
  parameter int RefrW      = 8,
  parameter int StepW      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  nrnStrobe_t            stb,
  input  logic                  cfgWe,
  input  logic [TableAddrW:0]   cfgAddr,
  input  logic [DataW-1:0]      cfgData,
  input  logic [DataW-1:0]      sumExc,
  input  logic [DataW-1:0]      sumInh,
  input  logic [DataW-1:0]      iExt,
  output logic [DataW-1:0]      vMem,
  output logic [DataW-1:0]      gExc,
  output logic [DataW-1:0]      gInh,
  output logic                  spike,
  output logic [StepW-1:0]      stepCount
);
  localparam int TabN = 1 << TableAddrW;
  localparam int NumW = 2*DataW + 2;

  // parameters
  q_t facExc, facInh, gLeak, vRest, eExc, eInh, vThresh;
  logic [RefrW-1:0] refrLen;
  q_t expTab [TabN];

  // state
  q_t sumExcQ, sumInhQ, iExtQ;
  q_t gExcQ, gInhQ, vMemQ, gTotQ;
  logic spikeQ, negQ;
  logic [RefrW-1:0] refrCnt;
  logic [StepW-1:0] stepQ;
  logic [NumW-1:0]  quoQ;
  logic [DataW:0]   remQ;

  // total conductance and numerator
  q_t gTotRaw, gTotC;
  logic signed [2*DataW-1:0] prodLeak, prodExc, prodInh;
  logic signed [NumW-1:0] iExtW, numWide;
  logic [NumW-1:0] numMag;

  always_comb begin
    gTotRaw  = satAdd(satAdd(gLeak, gExcQ), gInhQ);
    gTotC    = (gTotRaw < q_t'(1)) ? q_t'(1) : gTotRaw;
    prodLeak = gLeak * vRest;
    prodExc  = gExcQ * eExc;
    prodInh  = gInhQ * eInh;
    iExtW    = NumW'(iExtQ);
    iExtW    = iExtW <<< FracW;
    numWide  = NumW'(prodLeak) + NumW'(prodExc) + NumW'(prodInh) + iExtW;
    numMag   = (numWide < 0) ? NumW'(-numWide) : NumW'(numWide);
  end

  // restoring divider step
  logic [DataW:0] shifted;
  logic           fits;
  assign shifted = {remQ[DataW-1:0], quoQ[NumW-1]};
  assign fits    = (shifted >= {1'b0, gTotQ});

  // relaxation
  logic signed [WideW-1:0] quoW;
  q_t vInf, expV, vCand;
  logic [TableAddrW-1:0] tabIdx;

  always_comb begin
    quoW   = WideW'(quoQ);
    vInf   = satNarrow(negQ ? -quoW : quoW);
    tabIdx = gTotQ[DataW-2 -: TableAddrW];
    expV   = expTab[tabIdx];
    vCand  = satAdd(vInf, mulQ(satSub(vMemQ, vInf), expV));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      facExc <= '0; facInh <= '0; gLeak <= '0; vRest <= '0;
      eExc <= '0; eInh <= '0; vThresh <= '0; refrLen <= '0;
      for (int i = 0; i < TabN; i++) expTab[i] <= '0;
      sumExcQ <= '0; sumInhQ <= '0; iExtQ <= '0;
      gExcQ <= '0; gInhQ <= '0; vMemQ <= '0; gTotQ <= '0;
      spikeQ <= 1'b0; negQ <= 1'b0; refrCnt <= '0; stepQ <= '0;
      quoQ <= '0; remQ <= '0;
    end else begin
      if (cfgWe) begin
        if (cfgAddr[TableAddrW]) expTab[cfgAddr[TableAddrW-1:0]] <= cfgData;
        else begin
          unique case (cfgAddr[2:0])
            3'd0: facExc  <= cfgData;
            3'd1: facInh  <= cfgData;
            3'd2: gLeak   <= cfgData;
            3'd3: vRest   <= cfgData;
            3'd4: eExc    <= cfgData;
            3'd5: eInh    <= cfgData;
            3'd6: vThresh <= cfgData;
            3'd7: refrLen <= cfgData[RefrW-1:0];
            default: ;
          endcase
        end
      end
      if (stb.latchIn) begin
        sumExcQ <= sumExc;
        sumInhQ <= sumInh;
        iExtQ   <= iExt;
      end
      if (stb.updCond) begin
        gExcQ <= mulQ(satAdd(gExcQ, sumExcQ), facExc);
        gInhQ <= mulQ(satAdd(gInhQ, sumInhQ), facInh);
      end
      if (stb.prepDiv) begin
        gTotQ <= gTotC;
        quoQ  <= numMag;
        remQ  <= '0;
        negQ  <= (numWide < 0);
      end
      if (stb.divStep) begin
        remQ <= fits ? (shifted - {1'b0, gTotQ}) : shifted;
        quoQ <= {quoQ[NumW-2:0], fits};
      end
      if (stb.relax) begin
        if (refrCnt != '0) begin
          refrCnt <= refrCnt - 1'b1;
          spikeQ  <= 1'b0;
        end else if (vCand > vThresh) begin
          spikeQ  <= 1'b1;
          vMemQ   <= vRest;
          refrCnt <= refrLen;
        end else begin
          spikeQ  <= 1'b0;
          vMemQ   <= vCand;
        end
      end
      if (stb.bumpTime) stepQ <= stepQ + 1'b1;
    end
  end

  assign vMem      = vMemQ;
  assign gExc      = gExcQ;
  assign gInh      = gInhQ;
  assign spike     = spikeQ;
  assign stepCount = stepQ;

  p_gtot_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.relax |-> (gTotQ > q_t'(0)));
  p_spike_resets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.relax && !cfgWe) |=> (!spikeQ || vMemQ == vRest));
  p_refr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.relax && refrCnt != '0) |=> (!spikeQ && $stable(vMemQ)));
endmodule

// File: rtl/nrn_step_top.sv
module nrn_step_top
  import nrn_pkg::*;
#(
  parameter int TableAddrW = 6,
  parameter int RefrW      = 8,
  parameter int StepW      = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [TableAddrW:0] cfgAddr,
  input  logic [DataW-1:0]    cfgData,
  input  logic                start,
  input  logic [DataW-1:0]    sumExc,
  input  logic [DataW-1:0]    sumInh,
  input  logic [DataW-1:0]    iExt,
  output logic                busy,
  output logic                done,
  output logic                spike,
  output logic [DataW-1:0]    vMem,
  output logic [DataW-1:0]    gExc,
  output logic [DataW-1:0]    gInh,
  output logic [StepW-1:0]    stepCount
);
  localparam int DivSteps = 2*DataW + 2;

  nrnStrobe_t stb;

  nrn_ctrl #(.DivSteps(DivSteps)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .busy(busy), .done(done)
  );

  nrn_datapath #(.TableAddrW(TableAddrW), .RefrW(RefrW), .StepW(StepW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .sumExc(sumExc), .sumInh(sumInh), .iExt(iExt),
    .vMem(vMem), .gExc(gExc), .gInh(gInh),
    .spike(spike), .stepCount(stepCount)
  );
endmodule

// File: tb/tb_nrn_step_top.sv
module tb_nrn_step_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, cfgWe, start, busy, done, spike;
  logic [6:0]  cfgAddr;
  logic [15:0] cfgData, sumExc, sumInh, iExt, vMem, gExc, gInh, stepCount;

  nrn_step_top dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .start(start), .sumExc(sumExc), .sumInh(sumInh), .iExt(iExt),
    .busy(busy), .done(done), .spike(spike), .vMem(vMem),
    .gExc(gExc), .gInh(gInh), .stepCount(stepCount)
  );

  localparam int ExpLat = 38;

  int checks = 0, errors = 0;
  int mPrm [8];
  int mTab [64];
  int mV = 0, mGe = 0, mGi = 0, mRef = 0, mCnt = 0;
  bit mSpk = 0;

  function automatic int sat16(longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int mulq(int a, int b);
    longint p = longint'(a) * longint'(b);
    return sat16(p / 256);
  endfunction

  function automatic int s16(logic [15:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 7'(a); cfgData = 16'(d);
    @(negedge clk);
    cfgWe = 1'b0;
    if (a >= 64) mTab[a-64] = sat16(longint'(s16(16'(d))));
    else if ((a & 7) == 7) mPrm[7] = d & 255;
    else mPrm[a & 7] = s16(16'(d));
  endtask

  // reference step; commit=0 only predicts the candidate potential
  task automatic mdlStep(int se, int si, int ie, bit commit, output int vN);
    int ge, gi, gt, vInf, idx;
    longint num;
    ge = mulq(sat16(mGe + se), mPrm[0]);
    gi = mulq(sat16(mGi + si), mPrm[1]);
    gt = sat16(sat16(mPrm[2] + ge) + gi);
    if (gt < 1) gt = 1;
    num = longint'(mPrm[2]) * mPrm[3] + longint'(ge) * mPrm[4] +
          longint'(gi) * mPrm[5] + longint'(ie) * 256;
    vInf = sat16(num / gt);
    idx  = (gt >> 9) & 63;
    vN   = sat16(vInf + mulq(sat16(mV - vInf), mTab[idx]));
    if (commit) begin
      mGe = ge; mGi = gi; mCnt = (mCnt + 1) & 16'hffff;
      if (mRef > 0) begin mRef--; mSpk = 0; end
      else if (vN > mPrm[6]) begin mSpk = 1; mV = mPrm[3]; mRef = mPrm[7]; end
      else begin mSpk = 0; mV = vN; end
    end
  endtask

  task automatic runStep(int se, int si, int ie, bit extraStart = 1'b0);
    int lat, vN, extraDone;
    mdlStep(se, si, ie, 1'b1, vN);
    @(negedge clk);
    sumExc = 16'(se); sumInh = 16'(si); iExt = 16'(ie); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sumExc = 16'($urandom); sumInh = 16'($urandom); iExt = 16'($urandom);
    lat = 1;
    while (!done && lat < 200) begin
      if (extraStart && lat == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check("R10 latency", lat, ExpLat);
    check("R8 busy with done", busy, 1);
    check("R3 gExc", s16(gExc), mGe);
    check("R3 gInh", s16(gInh), mGi);
    check("R4 R5 vMem", s16(vMem), mV);
    check("R6 R7 spike", spike, mSpk);
    @(negedge clk);
    check("R8 done pulse", done, 0);
    check("R8 busy after done", busy, 0);
    check("R9 stepCount", stepCount, mCnt);
    if (extraStart) begin
      extraDone = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (done || busy) extraDone++;
      end
      check("R8 start while busy ignored", extraDone, 0);
      check("R8 R9 stepCount unchanged", stepCount, mCnt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual busy expected idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vN, seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) mPrm[i] = 0;
    for (int i = 0; i < 64; i++) mTab[i] = 0;
    rstN = 1'b0; cfgWe = 1'b0; start = 1'b0;
    cfgAddr = '0; cfgData = '0; sumExc = '0; sumInh = '0; iExt = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 spike", spike, 0);
    check("R1 vMem", vMem, 0);
    check("R1 gExc", gExc, 0);
    check("R1 gInh", gInh, 0);
    check("R1 stepCount", stepCount, 0);

    // R2 configuration through the write port
    cfgWrite(0, 230);            // excitatory decay ~0.9
    cfgWrite(1, 240);            // inhibitory decay ~0.94
    cfgWrite(2, 256);            // leak 1.0
    cfgWrite(3, -70*256);        // rest
    cfgWrite(4, 0);              // excitatory reversal
    cfgWrite(5, -80*256);        // inhibitory reversal
    cfgWrite(6, -54*256);        // threshold
    cfgWrite(7, 2);              // refractory steps
    for (int i = 0; i < 64; i++) cfgWrite(64 + i, 250 - 3*i);

    // random steps, R3..R7 and R9
    for (int n = 0; n < 80; n++)
      runStep(int'($urandom_range(0, 700)), int'($urandom_range(0, 300)),
              int'($urandom_range(0, 512)) - 256);

    // R8 start pulse while busy
    runStep(100, 20, 0, 1'b1);

    // R6 strict threshold: equal does not fire, one LSB above does
    while (mRef > 0) runStep(0, 0, 0);
    mdlStep(150, 10, 40, 1'b0, vN);
    cfgWrite(6, vN);
    runStep(150, 10, 40);
    check("R6 equal threshold no spike", spike, 0);
    while (mRef > 0) runStep(0, 0, 0);
    mdlStep(150, 10, 40, 1'b0, vN);
    cfgWrite(6, vN - 1);
    runStep(150, 10, 40);
    check("R6 above threshold spike", spike, 1);
    check("R6 reset to rest", s16(vMem), -70*256);
    cfgWrite(6, -54*256);

    // R7 refractory hold with strong drive
    cfgWrite(7, 3);
    for (int n = 0; n < 8; n++) runStep(1500, 0, 200);

    // R2 table rewrite changes the relaxation factor (R5)
    cfgWrite(64 + 0, 0);
    cfgWrite(64 + 1, 0);
    for (int n = 0; n < 4; n++) runStep(20, 20, 0);

    // R3 saturation: unit decay and maximal weights, gTot at table top
    cfgWrite(0, 256);
    runStep(32767, 0, 0);
    runStep(32767, 0, 0);
    check("R3 gExc saturated", s16(gExc), 32767);
    runStep(0, -32768, -32768);
    runStep(0, -32768, 32767);

    // R4 zero total conductance is floored to one LSB
    cfgWrite(0, 0);
    cfgWrite(1, 0);
    cfgWrite(2, 0);
    runStep(0, 0, 3);
    runStep(0, 0, -3);
    cfgWrite(2, 256);
    cfgWrite(0, 230);
    cfgWrite(1, 240);
    for (int n = 0; n < 20; n++)
      runStep(int'($urandom_range(0, 900)), int'($urandom_range(0, 400)),
              int'($urandom_range(0, 1024)) - 512);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule